// File: doc/BRIEF.md
# Parallel Poll Responder

This block lets a device answer a parallel poll on a byte-wide instrument bus. The controller opens a poll by holding the attention and end-or-identify management lines true together. While that condition lasts, the block reports one status bit on a single data line. It does this only if the device had a service request pending when the poll began.

The lines are open-collector. The block never drives a line false: it only raises a pull-down enable for the one line it uses, and that enable makes the shared line read true. Three things are captured on the clock edge where a poll is first seen: the line choice (a 3-bit index), the polarity of the response (the sense bit), and the service-request flag. Those captured values hold until the poll ends.

Top module: `pp_responder`

## Requirements
- R1: While `rst_ni` is low, every bit of `dio_pull_o` is 0.
- R2: A poll is recognised only when `atn_i` and `eoi_i` are both 1 at the same clock edge. With only one of them at 1, `dio_pull_o` stays 0.
- R3: If `srq_pend_i` is 0 at the edge where the poll is first recognised, `dio_pull_o` stays 0 for that whole poll.
- R4: The pulled line is the one at the bit position of `dio_pull_o` equal to `line_sel_i`. Value 0 selects bit 0, the first data line, and value 7 selects bit 7, the eighth.
- R5: A line is pulled only if `status_i` equals `sense_i` at poll entry. With `sense_i`=1, a status of 1 pulls the line. With `sense_i`=0, a status of 0 pulls it.
- R6: At most one bit of `dio_pull_o` is 1 at any time.
- R7: The response appears just after the first rising edge that samples both lines at 1. It is cleared just after the first rising edge that samples either line at 0.
- R8: During an active poll, changes to `srq_pend_i`, `line_sel_i`, `sense_i` or `status_i` do not alter `dio_pull_o`.
- R9: A new poll begins only after at least one edge where the two lines are not both 1. Every new poll captures fresh values of its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| atn_i | input | 1 | Attention line, 1 = true |
| eoi_i | input | 1 | End-or-identify line, 1 = true |
| srq_pend_i | input | 1 | Device has a service request pending |
| line_sel_i | input | 3 | Index of the data line used for the response |
| sense_i | input | 1 | Status value that produces a pulled line |
| status_i | input | 1 | Status bit being reported |
| dio_pull_o | output | 8 | Pull-down enables, one per data line |

## Verification
Each fault in the stored state shows up at the ports one edge after it occurs:
- A stuck poll-active flag keeps a line pulled after the poll ends, or never pulls one.
- A wrong captured index moves the pulled bit to another position.
- A captured hit flag that follows the live inputs lets mid-poll changes to the service request or status reach the bus.

Polls are therefore checked on the first cycle after entry, again several cycles later with the inputs disturbed, and on the first cycle after release.

// File: rtl/pp_resp_pkg.sv
package pp_resp_pkg;
  typedef enum logic {PP_IDLE = 1'b0, PP_ACTIVE = 1'b1} pp_phase_e;
endpackage

// File: rtl/pp_entry_det.sv
module pp_entry_det
  import pp_resp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic atn_i,
  input  logic eoi_i,
  output logic entry_o,
  output logic active_o
);
  logic      poll_now;
  pp_phase_e phase_q;

  assign poll_now = atn_i & eoi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= PP_IDLE;
    else if (poll_now) phase_q <= PP_ACTIVE;
    else               phase_q <= PP_IDLE;
  end

  // entry is seen before phase_q updates, so capture and activation share one edge
  assign entry_o  = poll_now & (phase_q == PP_IDLE);
  assign active_o = (phase_q == PP_ACTIVE);
endmodule

// File: rtl/pp_capture.sv
module pp_capture #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             srq_pend_i,
  input  logic [SEL_W-1:0] line_sel_i,
  input  logic             sense_i,
  input  logic             status_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             hit_o
);
  logic [SEL_W-1:0] sel_q;
  logic             hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      hit_q <= 1'b0;
    end else if (entry_i) begin
      sel_q <= line_sel_i;
      hit_q <= srq_pend_i & (status_i == sense_i);
    end
  end

  assign sel_o = sel_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/pp_line_drv.sv
module pp_line_drv #(
  parameter int LINES = 8,
  parameter int SEL_W = $clog2(LINES)
) (
  input  logic             active_i,
  input  logic             hit_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LINES-1:0] pull_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign pull_o[g] = active_i & hit_i & (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/pp_responder.sv
module pp_responder #(
  parameter int LINES = 8,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             atn_i,
  input  logic             eoi_i,
  input  logic             srq_pend_i,
  input  logic [SEL_W-1:0] line_sel_i,
  input  logic             sense_i,
  input  logic             status_i,
  output logic [LINES-1:0] dio_pull_o
);
  logic             entry;
  logic             active;
  logic [SEL_W-1:0] sel_cap;
  logic             hit_cap;

  pp_entry_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .atn_i   (atn_i),
    .eoi_i   (eoi_i),
    .entry_o (entry),
    .active_o(active)
  );

  pp_capture #(.SEL_W(SEL_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .entry_i   (entry),
    .srq_pend_i(srq_pend_i),
    .line_sel_i(line_sel_i),
    .sense_i   (sense_i),
    .status_i  (status_i),
    .sel_o     (sel_cap),
    .hit_o     (hit_cap)
  );

  pp_line_drv #(.LINES(LINES), .SEL_W(SEL_W)) u_drv (
    .active_i(active),
    .hit_i   (hit_cap),
    .sel_i   (sel_cap),
    .pull_o  (dio_pull_o)
  );
endmodule

// File: rtl/pp_responder_chk.sv
module pp_responder_chk #(
  parameter int LINES = 8,
  parameter int SEL_W = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             atn_i,
  input logic             eoi_i,
  input logic             srq_pend_i,
  input logic [SEL_W-1:0] line_sel_i,
  input logic             sense_i,
  input logic             status_i,
  input logic [LINES-1:0] dio_pull_o
);
  logic both;
  logic prev_both;
  assign both = atn_i & eoi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_both <= 1'b0;
    else         prev_both <= both;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (dio_pull_o == '0);
  end

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dio_pull_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both |=> (dio_pull_o == '0));

  assert_no_srq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && !prev_both && !srq_pend_i) |=> (dio_pull_o == '0));

  assert_line_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && !prev_both && srq_pend_i && (status_i == sense_i))
      |=> (dio_pull_o == (LINES'(1) << $past(line_sel_i))));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && prev_both) |=> $stable(dio_pull_o));
endmodule

bind pp_responder pp_responder_chk #(.LINES(LINES), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .atn_i     (atn_i),
  .eoi_i     (eoi_i),
  .srq_pend_i(srq_pend_i),
  .line_sel_i(line_sel_i),
  .sense_i   (sense_i),
  .status_i  (status_i),
  .dio_pull_o(dio_pull_o)
);

// File: tb/pp_responder_bench.sv
`timescale 1ns/1ps
module pp_responder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       atn_i = 1'b0, eoi_i = 1'b0, srq_pend_i = 1'b0;
  logic [2:0] line_sel_i = '0;
  logic       sense_i = 1'b1, status_i = 1'b1;
  logic [7:0] dio_pull_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pp_responder u_pp_responder (.*);

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic check(string req, logic [7:0] exp);
    total++;
    if (dio_pull_o !== exp || $countones(dio_pull_o) > 1) begin
      bad++;
      $display("FAIL %s: dio_pull_o=%b expected=%b", req, dio_pull_o, exp);
    end
  endtask

  task automatic bus(logic a, logic e);
    atn_i = a; eoi_i = e;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; bus(1, 1); srq_pend_i = 1;
    step(); check("R1", 8'h00);
    step(); check("R1", 8'h00);
    bus(0, 0); rst_ni = 1'b1; step();
  endtask

  task automatic t_single_line();
    srq_pend_i = 1; sense_i = 1; status_i = 1; line_sel_i = 3'd2;
    bus(1, 0); step(); step(); check("R2 atn only", 8'h00);
    bus(0, 1); step(); step(); check("R2 eoi only", 8'h00);
    bus(0, 0); step();
  endtask

  task automatic t_select();
    srq_pend_i = 1; sense_i = 1; status_i = 1;
    for (int i = 0; i < 8; i++) begin
      line_sel_i = 3'(i); bus(1, 1);
      step(); check("R4 R7 entry", 8'(1 << i));
      step(); step(); check("R4 held", 8'(1 << i));
      bus(i % 2 == 0 ? 1'b0 : 1'b1, i % 2 == 0 ? 1'b1 : 1'b0);
      step(); check("R7 release", 8'h00);
      bus(0, 0); step();
    end
  endtask

  task automatic t_no_srq();
    srq_pend_i = 0; line_sel_i = 3'd5; sense_i = 1; status_i = 1; bus(1, 1);
    step(); check("R3 entry", 8'h00);
    srq_pend_i = 1; step(); step(); check("R3 late srq", 8'h00);
    bus(0, 0); step();
  endtask

  task automatic t_sense();
    srq_pend_i = 1; line_sel_i = 3'd3;
    sense_i = 0; status_i = 1; bus(1, 1);
    step(); check("R5 mismatch", 8'h00);
    bus(0, 0); step();
    sense_i = 0; status_i = 0; bus(1, 1);
    step(); check("R5 sense0", 8'h08);
    bus(0, 0); step();
    sense_i = 1; status_i = 0; bus(1, 1);
    step(); check("R5 sense1 status0", 8'h00);
    bus(0, 0); step();
  endtask

  task automatic t_hold();
    srq_pend_i = 1; sense_i = 1; status_i = 1; line_sel_i = 3'd6; bus(1, 1);
    step(); check("R8 entry", 8'h40);
    srq_pend_i = 0; step(); check("R8 srq drop", 8'h40);
    line_sel_i = 3'd1; status_i = 0; sense_i = 1; step(); step();
    check("R8 sel/status change", 8'h40);
    bus(0, 0); step(); check("R7 after hold", 8'h00);
  endtask

  task automatic t_reentry();
    srq_pend_i = 1; sense_i = 1; status_i = 1; line_sel_i = 3'd0; bus(1, 1);
    step(); check("R9 first", 8'h01);
    bus(0, 1); srq_pend_i = 0; line_sel_i = 3'd7; step(); check("R9 gap", 8'h00);
    bus(1, 1); step(); check("R9 no srq second", 8'h00);
    bus(1, 0); srq_pend_i = 1; step();
    bus(1, 1); step(); check("R9 fresh capture", 8'h80);
    bus(0, 0); step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_line();
    t_select();
    t_no_srq();
    t_sense();
    t_hold();
    t_reentry();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule